// File: doc/BRIEF.md
# Conditional Return Evaluator

This unit sits in the execute stage of a stack processor. It handles the instructions that return from a word only when a relational test passes. Each cycle it takes a 6-bit opcode, the two topmost data stack values, a double-return choice made by the instruction decoder, and an instruction-valid strobe. One clock later it reports four things to the return-stack and data-stack control: whether to return, whether the return pops two frames, how many data stack items to discard, and whether the deepest argument stays in place.

Six relational tests share a 3-bit condition field. Three single-bit modifiers sit beside that field:
- a zero modifier, which tests the top item against an implied zero,
- an unsigned modifier, which changes the ordering from two's-complement to unsigned,
- a keep modifier, which leaves the deepest argument on the stack.

A passing test triggers a return. It never pushes a flag.

Top module: `cond_ret_unit`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it goes low, all four outputs are 0.
- R2: The condition field is `op_code[2:0]`. The codes are 0 less, 1 less-or-equal, 2 equal, 3 not-equal, 4 greater-or-equal and 5 greater. `ret_take` is registered: it shows, one cycle after the inputs, whether `op_valid` was high and the selected test held.
- R3: Condition codes 6 and 7 never assert `ret_take`, for any operand values.
- R4: When `op_code[3]` is 0, the test compares NOS (left side) against TOS (right side), for example NOS < TOS.
- R5: When `op_code[3]` is 1, the test compares TOS (left side) against an implied zero, and NOS has no effect.
- R6: When `op_code[4]` is 1, the ordering is unsigned. When it is 0, the ordering is signed two's-complement.
- R7: For a valid instruction, whether or not the test passes, `drop_cnt` is 2 for two-argument forms and 1 for zero forms, less 1 when the keep bit `op_code[5]` is set. `keep_arg` equals that keep bit.
- R8: `ret_double` is high exactly when `ret_take` is high and `is_double` was high with the instruction.
- R9: One cycle after a cycle with `op_valid` low, all four outputs are 0, whatever the other inputs were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction-valid strobe for a conditional return |
| op_code | input | 6 | Condition field [2:0], zero bit [3], unsigned bit [4], keep bit [5] |
| is_double | input | 1 | Decoder choice: the return pops two frames |
| tos | input | DATA_W | Top of data stack |
| nos | input | DATA_W | Next on data stack |
| ret_take | output | 1 | Perform the return |
| ret_double | output | 1 | The return is a double return |
| drop_cnt | output | 2 | Number of data stack items to discard |
| keep_arg | output | 1 | Deepest argument is kept |

## Verification
A wrong operand pick, a wrong sign handling or a wrong condition decode appears on `ret_take` in the cycle right after the offending instruction. The operand pairs are chosen around the sign boundary and around equality so that each of these faults flips the result. A stuck or mis-decoded modifier shows on `drop_cnt` or `keep_arg` one cycle later, even when the test fails. Because the outputs are registered and carry no history, a fault can never stay hidden for more than one instruction.

// File: rtl/crc_pkg.sv
package crc_pkg;

  typedef enum logic [2:0] {
    CND_LT = 3'd0,
    CND_LE = 3'd1,
    CND_EQ = 3'd2,
    CND_NE = 3'd3,
    CND_GE = 3'd4,
    CND_GT = 3'd5,
    CND_X6 = 3'd6,
    CND_X7 = 3'd7
  } cnd_e;

  typedef struct packed {
    cnd_e cnd;
    logic zero_rhs;
    logic unsig;
    logic keep;
  } crc_fields_t;

  localparam int OP_W = 6;

  function automatic logic cnd_eval(cnd_e c, logic lt, logic eq);
    logic r;
    case (c)
      CND_LT:  r = lt;
      CND_LE:  r = lt | eq;
      CND_EQ:  r = eq;
      CND_NE:  r = ~eq;
      CND_GE:  r = ~lt;
      CND_GT:  r = ~lt & ~eq;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/crc_decode.sv
module crc_decode
  import crc_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output crc_fields_t     fld
);
  always_comb begin
    fld.cnd      = cnd_e'(op[2:0]);
    fld.zero_rhs = op[3];
    fld.unsig    = op[4];
    fld.keep     = op[5];
  end
endmodule

// File: rtl/crc_compare.sv
module crc_compare #(
  parameter int W = 16
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic         unsig,
  output logic         lt,
  output logic         eq
);
  localparam int MSB = W - 1;
  logic [W-1:0] lb, rb;

  generate
    if (W > 1) begin : g_wide
      assign lb = {lhs[MSB] ^ ~unsig, lhs[MSB-1:0]};
      assign rb = {rhs[MSB] ^ ~unsig, rhs[MSB-1:0]};
    end else begin : g_bit
      assign lb = lhs ^ {W{~unsig}};
      assign rb = rhs ^ {W{~unsig}};
    end
  endgenerate

  assign lt = (lb < rb);
  assign eq = (lhs == rhs);
endmodule

// File: rtl/cond_ret_unit.sv
module cond_ret_unit
  import crc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [5:0]        op_code,
  input  logic              is_double,
  input  logic [DATA_W-1:0] tos,
  input  logic [DATA_W-1:0] nos,
  output logic              ret_take,
  output logic              ret_double,
  output logic [1:0]        drop_cnt,
  output logic              keep_arg
);
  crc_fields_t fld;
  logic [DATA_W-1:0] lhs, rhs;
  logic lt, eq, hit;
  logic [1:0] drops;

  crc_decode u_dec (.op(op_code), .fld(fld));

  assign lhs = fld.zero_rhs ? tos : nos;
  assign rhs = fld.zero_rhs ? '0  : tos;

  crc_compare #(.W(DATA_W)) u_cmp (
    .lhs(lhs), .rhs(rhs), .unsig(fld.unsig), .lt(lt), .eq(eq)
  );

  assign hit   = cnd_eval(fld.cnd, lt, eq);
  assign drops = (fld.zero_rhs ? 2'd1 : 2'd2) - {1'b0, fld.keep};

  always_ff @(posedge clk) begin
    if (rst || !op_valid) begin
      ret_take   <= 1'b0;
      ret_double <= 1'b0;
      drop_cnt   <= 2'd0;
      keep_arg   <= 1'b0;
    end else begin
      ret_take   <= hit;
      ret_double <= hit & is_double;
      drop_cnt   <= drops;
      keep_arg   <= fld.keep;
    end
  end
endmodule

// File: rtl/crc_checker.sv
module crc_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [5:0]        op_code,
  input logic              is_double,
  input logic [DATA_W-1:0] tos,
  input logic              ret_take,
  input logic              ret_double,
  input logic [1:0]        drop_cnt,
  input logic              keep_arg
);
  AST_DOUBLE_NEEDS_TAKE: assert property (@(posedge clk) disable iff (rst)
    ret_double |-> ret_take); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!ret_take && !ret_double && drop_cnt == 2'd0 && !keep_arg)); // R9
  AST_NEVER_CODES: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code[2:1] == 2'b11) |=> !ret_take); // R3
  AST_ZERO_EQ_HIT: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code[3:0] == 4'b1010 && tos == '0) |=> ret_take); // R5
  AST_KEEP_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (keep_arg == $past(op_code[5]))); // R7
  AST_DROP_RANGE: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (drop_cnt == 2'd2 - {1'b0, $past(op_code[3])} - {1'b0, $past(op_code[5])})); // R7
  AST_DOUBLE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (ret_double == (ret_take && $past(is_double)))); // R8
endmodule

bind cond_ret_unit crc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .is_double(is_double), .tos(tos), .ret_take(ret_take),
  .ret_double(ret_double), .drop_cnt(drop_cnt), .keep_arg(keep_arg)
);

// File: tb/sim_cond_ret_unit.sv
`timescale 1ns/1ps
module sim_cond_ret_unit;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [5:0] op_code = '0;
  logic is_double = 1'b0;
  logic [W-1:0] tos = '0, nos = '0;
  logic ret_take, ret_double, keep_arg;
  logic [1:0] drop_cnt;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cond_ret_unit #(.DATA_W(W)) u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .is_double(is_double), .tos(tos), .nos(nos), .ret_take(ret_take),
    .ret_double(ret_double), .drop_cnt(drop_cnt), .keep_arg(keep_arg)
  );

  function automatic longint sval(logic [W-1:0] v, bit uns);
    if (uns || !v[W-1]) return longint'(v);
    return longint'(v) - (longint'(1) << W);
  endfunction

  function automatic bit ref_test(int cnd, longint a, longint b);
    case (cnd)
      0: return a < b;
      1: return a <= b;
      2: return a == b;
      3: return a != b;
      4: return a >= b;
      5: return a > b;
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, logic [4:0] got, logic [4:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: take/dbl/drop/keep actual=%b expected=%b", tag, got, exp);
    end
  endtask

  // Drive at a falling edge, compare at the next falling edge.
  task automatic step(string tag, bit v, logic [5:0] op, bit dbl,
                      logic [W-1:0] t, logic [W-1:0] n);
    bit uns, zr, kp, hit;
    longint a, b;
    logic [4:0] e;
    op_valid = v; op_code = op; is_double = dbl; tos = t; nos = n;
    uns = op[4]; zr = op[3]; kp = op[5];
    a = zr ? sval(t, uns) : sval(n, uns);
    b = zr ? 0 : sval(t, uns);
    hit = v && ref_test(int'(op[2:0]), a, b);
    if (v) e = {hit, hit && dbl, 2'(2 - int'(zr) - int'(kp)), kp};
    else   e = 5'b0;
    @(negedge clk);
    check(tag, {ret_take, ret_double, drop_cnt, keep_arg}, e);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    op_valid = 1'b1; op_code = 6'b000011; tos = 16'd1; nos = 16'd2;
    repeat (3) @(negedge clk);
    check("R1", {ret_take, ret_double, drop_cnt, keep_arg}, 5'b0);
    rst = 1'b0;
    op_valid = 1'b0;
    @(negedge clk);
    check("R1", {ret_take, ret_double, drop_cnt, keep_arg}, 5'b0);

    // R2 each condition code, two-argument signed
    for (int c = 0; c < 6; c++) begin
      step("R2", 1, 6'(c), 0, 16'd5, 16'd3);
      step("R2", 1, 6'(c), 0, 16'd5, 16'd5);
      step("R2", 1, 6'(c), 0, 16'd3, 16'd5);
    end
    // R3 never-true codes
    step("R3", 1, 6'd6, 1, 16'd0, 16'd0);
    step("R3", 1, 6'd7, 1, 16'd9, 16'd1);
    step("R3", 1, 6'b111111, 1, 16'h8000, 16'h7fff);
    // R4 operand order: NOS < TOS
    step("R4", 1, 6'd0, 0, 16'd10, 16'd2);
    step("R4", 1, 6'd0, 0, 16'd2, 16'd10);
    // R5 zero forms, NOS ignored
    step("R5", 1, 6'b001010, 0, 16'd0, 16'd77);
    step("R5", 1, 6'b001000, 0, 16'hffff, 16'd0);
    step("R5", 1, 6'b001101, 0, 16'd1, 16'hffff);
    // R6 signed versus unsigned across the sign boundary
    step("R6", 1, 6'b000000, 0, 16'd1, 16'h8000);
    step("R6", 1, 6'b010000, 0, 16'd1, 16'h8000);
    step("R6", 1, 6'b011000, 0, 16'hffff, 16'd0);
    step("R6", 1, 6'b001000, 0, 16'hffff, 16'd0);
    // R7 drop counts, also on a failing test
    step("R7", 1, 6'b100010, 0, 16'd1, 16'd2);
    step("R7", 1, 6'b101011, 0, 16'd0, 16'd2);
    step("R7", 1, 6'b001011, 0, 16'd0, 16'd2);
    // R8 double return
    step("R8", 1, 6'd2, 1, 16'd4, 16'd4);
    step("R8", 1, 6'd3, 1, 16'd4, 16'd4);
    // R9 strobe low
    step("R9", 0, 6'd2, 1, 16'd4, 16'd4);
    step("R9", 0, 6'b101000, 1, 16'd0, 16'd0);
    // mixed sweep
    for (int i = 0; i < 400; i++) begin
      logic [5:0] op;
      logic [W-1:0] t, n;
      op = 6'($urandom);
      t = (i % 4 == 0) ? 16'h8000 : W'($urandom);
      n = (i % 3 == 0) ? t : W'($urandom);
      step(op[3] ? "R5" : "R4", (i % 7) != 0, op, 1'($urandom), t, n);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule